// File: doc/BRIEF.md
# Current-Limit Comparator Qualifier

This block sits between an analog current-sense comparator and the PWM stage of a motor controller. It takes the raw one-bit comparator decision, brings it into the peripheral clock domain and holds it off for a start-up interval after the comparator is powered. It then qualifies rising transitions through a selectable number of consecutive agreeing samples. A qualified rise latches a sticky current-limit flag and, a fixed number of motor-timer ticks later, drives a PWM-kill line that forces the power stage off.

The block runs on one peripheral clock. The motor-timer clock is a one-cycle enable pulse, `mtc_en`, on that clock. The comparator counts as powered when either of its two enable sources is high. A filter selection of 0 takes a single detection as valid. A selection x from 1 to 7 samples the synchronised bit once every 4 peripheral clocks and needs x+1 agreeing samples in a row. After qualification the event crosses into the motor-timer tick domain through a short pipeline. The flag and the kill line therefore rise on fixed, known ticks. The flag stays set until software pulses the clear input. All pins are plain level controls, and no pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `curlim_guard`

## Requirements
- R1: After reset, `lim_flag` and `pwm_kill` are 0.
- R2: While both `cmp_clk_en` and `dac_en` are 0, and for 4 `mtc_en` ticks after either one rises, the comparator is ignored. A level still high when this interval ends is then treated as a rise. With `mtc_en` held high, filter 0, and enable and a high comparator applied together before clock edge 1, the flag is still 0 after edge 8 and is 1 after edge 9. Either enable source alone powers the comparator.
- R3: With filter 0 and `mtc_en` held high, a comparator rise applied before edge 1 leaves `lim_flag` at 0 after edge 5 and sets it after edge 6.
- R4: With filter x in 1..7 and `mtc_en` held high, a comparator rise applied before edge 1 and held high sets `lim_flag` after an edge n, where 5+4x <= n <= 8+4x.
- R5: `pwm_kill` rises exactly 2 `mtc_en` ticks after `lim_flag` rises, provided the flag is not cleared between the two.
- R6: With filter x, any sample that disagrees with the pending level restarts the count. A high run of at most 4x clocks, and a train of 8-clock highs separated by 4-clock lows under x=3, never set the flag.
- R7: Only a rising comparator output triggers. A fall of the input, however long, does not set the flag.
- R8: Once set, `lim_flag` stays 1 until `flag_clr` is sampled high. `pwm_kill` stays 1 while the flag is 1.
- R9: When a new event sets the flag in the same cycle as `flag_clr` is high, the flag remains 1.
- R10: When `flag_clr` clears the flag at edge e, `pwm_kill` is still 1 after edge e and is 0 after edge e+1.
- R11: `filt_sel` (3 bits, x = value) is captured only while both enable sources are 0. Changes made while the comparator is enabled have no effect on the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mtc_en | input | 1 | Motor-timer clock enable, one-cycle pulse per tick |
| cmp_clk_en | input | 1 | Comparator enable source: clock enable |
| dac_en | input | 1 | Comparator enable source: reference DAC enable |
| filt_sel | input | SEL_W (3) | Filter selection x; x+1 agreeing samples needed, 0 = single detection |
| cmp_raw | input | 1 | Asynchronous comparator output |
| flag_clr | input | 1 | Clear pulse for the current-limit flag |
| lim_flag | output | 1 | Sticky current-limit flag |
| pwm_kill | output | 1 | Forces PWM outputs to their off state |

## Verification
A corrupted sample counter or divider phase shows up as a flag edge outside the window of x+1 sample periods. With `mtc_en` held high, that window is at most 4 clocks wide. A tripped bench check is therefore seen within about 40 clocks of the stimulus. A broken blanking counter makes a pulse during start-up set the flag, or moves the held-high trip away from edge 9. A fault in the tick pipeline moves the flag-to-kill gap away from exactly 2 ticks. A wrong clear or set priority shows on the very next edge as a flag that drops, or a kill line that outlives the flag by more than one cycle.

// File: rtl/curlim_pkg.sv
package curlim_pkg;
  // Tick-pipeline taps: the flag is taken one stage later in single-detection
  // mode, and the kill line always trails the flag by a fixed gap.
  localparam int FLAG_TAP_MULTI  = 0;
  localparam int FLAG_TAP_SINGLE = 1;
  localparam int KILL_GAP        = 2;
  localparam int TRIP_DEPTH      = FLAG_TAP_SINGLE + KILL_GAP + 1;
endpackage

// File: rtl/curlim_sync.sv
module curlim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/curlim_blank.sv
module curlim_blank #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mtc_en,
  input  logic cmp_on,
  output logic blanked
);
  localparam int CW = $clog2(TICKS + 1);

  logic          on_q;
  logic [CW-1:0] left_q;
  logic          on_rise;

  assign on_rise = cmp_on & ~on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else begin
      on_q <= cmp_on;
      if (!cmp_on)                        left_q <= '0;
      else if (on_rise)                   left_q <= CW'(TICKS);
      else if (mtc_en && left_q != '0)    left_q <= left_q - 1'b1;
    end
  end

  assign blanked = ~cmp_on | on_rise | (left_q != '0);

  AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |=> (left_q == CW'(TICKS))); // R2
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_on && !on_rise && !mtc_en) |=> $stable(left_q)); // R2
endmodule

// File: rtl/curlim_qual.sv
module curlim_qual #(
  parameter int SEL_W      = 3,
  parameter int SAMPLE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blanked,
  input  logic             sel_load,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             smp,
  output logic             rise_ev,
  output logic             single
);
  localparam int DW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [DW-1:0]    div_q;
  logic [SEL_W-1:0] x_q;
  logic [SEL_W-1:0] run_q;
  logic             lvl_q;
  logic             ev_q;
  logic             tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          div_q <= '0;
    else if (div_q == DW'(SAMPLE_DIV-1)) div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        x_q <= '0;
    else if (sel_load) x_q <= sel_in;
  end

  assign single = (x_q == '0);
  assign tick   = single | (div_q == DW'(SAMPLE_DIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
      ev_q  <= 1'b0;
    end else begin
      ev_q <= 1'b0;
      if (blanked) begin
        lvl_q <= 1'b0;
        run_q <= '0;
      end else if (tick) begin
        if (smp == lvl_q) begin
          run_q <= '0;
        end else if (run_q == x_q) begin
          lvl_q <= smp;
          run_q <= '0;
          ev_q  <= smp;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign rise_ev = ev_q;

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= x_q); // R6
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    blanked |=> !ev_q); // R2
  AST_FALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && !smp) |=> !ev_q); // R7
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> $stable(x_q)); // R11
endmodule

// File: rtl/curlim_trip.sv
module curlim_trip
  import curlim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mtc_en,
  input  logic rise_ev,
  input  logic single,
  input  logic flag_clr,
  output logic flag,
  output logic kill
);
  logic [TRIP_DEPTH-1:0] stg_q;
  logic                  pend_q;
  logic                  flag_q;
  logic                  kill_q;
  logic                  flag_set;
  logic                  kill_set;
  logic                  flag_tap;
  logic                  kill_tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      pend_q <= 1'b0;
    end else if (mtc_en) begin
      stg_q  <= {stg_q[TRIP_DEPTH-2:0], pend_q | rise_ev};
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_q | rise_ev;
    end
  end

  assign flag_tap = single ? stg_q[FLAG_TAP_SINGLE] : stg_q[FLAG_TAP_MULTI];
  assign kill_tap = single ? stg_q[FLAG_TAP_SINGLE + KILL_GAP]
                           : stg_q[FLAG_TAP_MULTI + KILL_GAP];
  assign flag_set = mtc_en & flag_tap;
  assign kill_set = mtc_en & kill_tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      flag_q <= flag_set | (flag_q & ~flag_clr);
      kill_q <= flag_q & (kill_set | kill_q);
    end
  end

  assign flag = flag_q;
  assign kill = kill_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set && flag_clr) |=> flag_q); // R9
  AST_KILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |=> !kill_q); // R10
  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && flag_q) |=> kill_q); // R8
endmodule

// File: rtl/curlim_guard.sv
module curlim_guard #(
  parameter int SEL_W         = 3,
  parameter int SAMPLE_DIV    = 4,
  parameter int STARTUP_TICKS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mtc_en,
  input  logic             cmp_clk_en,
  input  logic             dac_en,
  input  logic [SEL_W-1:0] filt_sel,
  input  logic             cmp_raw,
  input  logic             flag_clr,
  output logic             lim_flag,
  output logic             pwm_kill
);
  logic cmp_on;
  logic cmp_s;
  logic blanked;
  logic rise_ev;
  logic single;

  assign cmp_on = cmp_clk_en | dac_en;

  curlim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_s)
  );

  curlim_blank #(.TICKS(STARTUP_TICKS)) u_blank (
    .clk(clk), .rst_n(rst_n), .mtc_en(mtc_en), .cmp_on(cmp_on),
    .blanked(blanked)
  );

  curlim_qual #(.SEL_W(SEL_W), .SAMPLE_DIV(SAMPLE_DIV)) u_qual (
    .clk(clk), .rst_n(rst_n), .blanked(blanked), .sel_load(~cmp_on),
    .sel_in(filt_sel), .smp(cmp_s), .rise_ev(rise_ev), .single(single)
  );

  curlim_trip u_trip (
    .clk(clk), .rst_n(rst_n), .mtc_en(mtc_en), .rise_ev(rise_ev),
    .single(single), .flag_clr(flag_clr), .flag(lim_flag), .kill(pwm_kill)
  );

  AST_OFF_NO_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_on && !lim_flag) |=> !lim_flag); // R2
endmodule

// File: tb/test_curlim_guard.sv
module test_curlim_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mtc_en;
  logic       cmp_clk_en;
  logic       dac_en;
  logic [2:0] filt_sel;
  logic       cmp_raw;
  logic       flag_clr;
  logic       lim_flag;
  logic       pwm_kill;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  curlim_guard i_curlim_guard (
    .clk(clk), .rst_n(rst_n), .mtc_en(mtc_en), .cmp_clk_en(cmp_clk_en),
    .dac_en(dac_en), .filt_sel(filt_sel), .cmp_raw(cmp_raw),
    .flag_clr(flag_clr), .lim_flag(lim_flag), .pwm_kill(pwm_kill)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // one posedge, then settle at the following negedge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic power_up(input logic [2:0] sel, input bit use_dac);
    cmp_clk_en = 1'b0; dac_en = 1'b0; cmp_raw = 1'b0; filt_sel = sel;
    step(3);
    if (use_dac) dac_en = 1'b1; else cmp_clk_en = 1'b1;
    step(8);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    step(1);
  endtask

  // drive a rise, return the edges until flag and until kill
  task automatic measure(output int fe, output int ke);
    fe = 0; ke = 0;
    cmp_raw = 1'b1;
    for (int n = 1; n <= 200; n++) begin
      step(1);
      if (lim_flag && fe == 0) fe = n;
      if (pwm_kill) begin ke = n; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", lim_flag, 0);
    chk("R1 kill after reset", pwm_kill, 0);
  endtask

  task automatic t_single();
    power_up(3'd0, 1'b0);
    cmp_raw = 1'b1;
    step(5);  chk("R3 flag after edge 5", lim_flag, 0);
    step(1);  chk("R3 flag after edge 6", lim_flag, 1);
    step(1);  chk("R5 kill after edge 7", pwm_kill, 0);
    step(1);  chk("R5 kill after edge 8", pwm_kill, 1);
    step(10);
    chk("R8 flag held", lim_flag, 1);
    chk("R8 kill held", pwm_kill, 1);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R10 flag cleared at e", lim_flag, 0);
    chk("R10 kill still set at e", pwm_kill, 1);
    step(1);
    chk("R10 kill low at e+1", pwm_kill, 0);
    cmp_raw = 1'b0;
    step(30);
    chk("R7 falling edge ignored", lim_flag, 0);
  endtask

  task automatic t_multi(input int x);
    int fe, ke;
    power_up(3'(x), 1'b0);
    measure(fe, ke);
    chk_rng($sformatf("R4 flag edge x=%0d", x), fe, 5 + 4 * x, 8 + 4 * x);
    chk($sformatf("R5 kill gap x=%0d", x), ke - fe, 2);
    cmp_raw = 1'b0;
    step(40);
    clear_flag();
  endtask

  task automatic t_glitch();
    power_up(3'd3, 1'b0);
    for (int k = 0; k < 6; k++) begin
      cmp_raw = 1'b1; step(8);
      cmp_raw = 1'b0; step(4);
    end
    cmp_raw = 1'b1; step(12);
    cmp_raw = 1'b0; step(30);
    chk("R6 short highs rejected", lim_flag, 0);
    chk("R6 no kill", pwm_kill, 0);
  endtask

  task automatic t_blank();
    // pulse inside the start-up window is ignored
    cmp_clk_en = 1'b0; dac_en = 1'b0; cmp_raw = 1'b0; filt_sel = 3'd0;
    step(3);
    cmp_clk_en = 1'b1; cmp_raw = 1'b1;
    step(3);
    cmp_raw = 1'b0;
    step(30);
    chk("R2 pulse in start-up ignored", lim_flag, 0);
    // level held high from enable: seen only when blanking ends (dac source)
    cmp_clk_en = 1'b0;
    step(3);
    dac_en = 1'b1; cmp_raw = 1'b1;
    step(8);  chk("R2 flag after edge 8", lim_flag, 0);
    step(1);  chk("R2 flag after edge 9", lim_flag, 1);
    cmp_raw = 1'b0;
    step(10);
    clear_flag();
    // disabled comparator never trips
    dac_en = 1'b0;
    step(2);
    cmp_raw = 1'b1;
    step(30);
    chk("R2 disabled comparator ignored", lim_flag, 0);
    cmp_raw = 1'b0;
    step(3);
  endtask

  task automatic t_set_wins();
    power_up(3'd0, 1'b1);
    cmp_raw = 1'b1;
    step(12);
    chk("R9 precondition flag", lim_flag, 1);
    cmp_raw = 1'b0;
    step(10);
    cmp_raw = 1'b1;
    step(5);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R9 set beats clear", lim_flag, 1);
    step(3);
    chk("R9 flag stays", lim_flag, 1);
    cmp_raw = 1'b0;
    step(10);
    clear_flag();
    step(2);
  endtask

  task automatic t_sel_locked();
    int fe, ke;
    power_up(3'd3, 1'b0);
    filt_sel = 3'd0;
    step(2);
    measure(fe, ke);
    chk_rng("R11 selection change while enabled ignored", fe, 17, 20);
    cmp_raw = 1'b0;
    step(40);
    clear_flag();
  endtask

  initial begin
    rst_n = 1'b0; mtc_en = 1'b1; cmp_clk_en = 1'b0; dac_en = 1'b0;
    filt_sel = 3'd0; cmp_raw = 1'b0; flag_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_multi(1);
    t_multi(3);
    t_multi(7);
    t_glitch();
    t_blank();
    t_set_wins();
    t_sel_locked();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule